// File: doc/BRIEF.md
# Sync Presence Detector with Mute

This block decides whether a usable video signal is present by timing a separated horizontal sync pulse stream against a free-running system clock. Every line period is measured from one rising sync edge to the next and classed as in range or out of range. A three-state policy (enabled, probation, muted) uses these verdicts to decide whether a bus of already separated sync signals passes through unchanged or is held at logic high.

An out-of-range line or a loss of pulses does not mute the outputs at once. It starts a grace timer, nominally 2.5 ms, and the outputs keep passing during that time. A run of eight consecutive in-range lines ends the grace period and cancels the mute. If the timer runs out first, the outputs go high. From then on they stay high until another run of eight consecutive in-range lines arrives. The default window is 6345 to 10684 cycles of a 125 MHz clock, which is about 19.7 kHz down to 11.7 kHz. All limits are parameters.

Top module: `sync_presence_mute`

## Requirements
- R1: After reset the block is muted. `syncPresent` is 0, every bit of `gatedSync` is 1, and the valid-line run count is zero.
- R2: A line is in range when the number of clock cycles between two consecutive rising edges of the synchronized `hsyncIn` is at least MIN_PERIOD and at most MAX_PERIOD, both limits included. Any other period is out of range. The first edge after reset is always out of range.
- R3: While muted, the RUN_LINES-th consecutive in-range line enables the block: `syncPresent` goes to 1 and the outputs pass through. One line fewer leaves it muted.
- R4: An out-of-range line clears the run count to zero, so the recovery lines must be consecutive. This holds both while muted and during probation.
- R5: When `syncPresent` is 1, `gatedSync` equals `rawSync` bit for bit, whatever pattern `rawSync` carries.
- R6: In the enabled state, an out-of-range line starts probation. During probation `syncPresent` stays 1 and the outputs keep passing.
- R7: If no rising edge arrives within MAX_PERIOD+1 cycles of the previous one, this counts as one out-of-range line. The period counter then stays saturated until the next edge.
- R8: If probation lasts PROB_CYCLES cycles without a completed recovery run, the block mutes: `syncPresent` becomes 0 and `gatedSync` is all ones.
- R9: RUN_LINES consecutive in-range lines during probation return the block to enabled and cancel the timer. A later stretch of valid lines longer than PROB_CYCLES does not mute it.
- R10: If the RUN_LINES-th in-range line is detected in the same cycle that the probation timer expires, recovery wins and the block returns to enabled.
- R11: An out-of-range line during probation does not restart the probation timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that times the line periods |
| rst | input | 1 | Synchronous active-high reset |
| hsyncIn | input | 1 | Separated horizontal sync pulse, asynchronous to clk |
| rawSync | input | OUT_W | Sync signals to be gated |
| gatedSync | output | OUT_W | `rawSync` when a signal is present, all ones when muted |
| syncPresent | output | 1 | 1 in the enabled and probation states, 0 when muted |

## Verification
The probation timer expiring and the eighth recovery line being counted can land in the same clock cycle. The bench forces this collision directly. It sends one out-of-range line to an enabled block and follows it with eight lines whose period is exactly one eighth of PROB_CYCLES, so the last valid edge is detected in the cycle the timer reaches its final count. The result is judged at `syncPresent` one line later: a muted block would have cleared its run and dropped the flag, while the required result keeps it at 1. The bench also checks the related case where a bad line during probation must not restart the timer, by placing the expected mute at a point the restarted timer would not yet have reached.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;

  typedef enum logic [1:0] {
    ST_MUTED     = 2'd0,
    ST_ENABLED   = 2'd1,
    ST_PROBATION = 2'd2
  } det_state_t;

  // Strobes from the control FSM to the counting datapath.
  typedef struct packed {
    logic probStart;  // load the grace timer with zero
    logic probRun;    // advance the grace timer
    logic runInc;     // count one more in-range line
    logic runClr;     // clear the recovery run (wins over runInc)
  } det_strobe_t;

endpackage

// File: rtl/syncdet_datapath.sv
module syncdet_datapath
  import syncdet_pkg::*;
#(
  parameter int MIN_PERIOD  = 6345,
  parameter int MAX_PERIOD  = 10684,
  parameter int PROB_CYCLES = 312500,
  parameter int RUN_LINES   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hsyncIn,
  input  det_strobe_t strobe,
  output logic        lineValid,
  output logic        lineBad,
  output logic        runLast,
  output logic        probExpired
);

  localparam int PER_LIMIT = MAX_PERIOD + 1;
  localparam int PER_W     = $clog2(PER_LIMIT + 1);
  localparam int RUN_W     = $clog2(RUN_LINES + 1);
  localparam int PROB_W    = $clog2(PROB_CYCLES + 1);

  localparam logic [PER_W-1:0]  PER_LIM_V  = PER_W'(PER_LIMIT);
  localparam logic [PER_W-1:0]  PER_MAX_V  = PER_W'(MAX_PERIOD);
  localparam logic [PER_W:0]    WIN_MIN_V  = (PER_W+1)'(MIN_PERIOD);
  localparam logic [PER_W:0]    WIN_MAX_V  = (PER_W+1)'(MAX_PERIOD);
  localparam logic [RUN_W-1:0]  RUN_LAST_V = RUN_W'(RUN_LINES - 1);
  localparam logic [RUN_W-1:0]  RUN_V      = RUN_W'(RUN_LINES);
  localparam logic [PROB_W-1:0] PROB_LAST_V = PROB_W'(PROB_CYCLES - 1);

  // Two synchronizer flops plus one history flop for edge detection.
  logic [2:0] syncPipe;
  logic       syncEdge;

  always_ff @(posedge clk) begin
    if (rst) syncPipe <= '0;
    else     syncPipe <= {syncPipe[1:0], hsyncIn};
  end

  assign syncEdge = syncPipe[1] & ~syncPipe[2];

  // Cycles since the last edge; the measured period is count + 1.
  logic [PER_W-1:0] perCnt;
  logic [PER_W:0]   measured;
  logic             inWindow;
  logic             timeout;

  always_ff @(posedge clk) begin
    if (rst)                    perCnt <= PER_LIM_V;
    else if (syncEdge)          perCnt <= '0;
    else if (perCnt != PER_LIM_V) perCnt <= perCnt + PER_W'(1);
  end

  assign measured  = {1'b0, perCnt} + (PER_W+1)'(1);
  assign inWindow  = (measured >= WIN_MIN_V) && (measured <= WIN_MAX_V);
  assign timeout   = !syncEdge && (perCnt == PER_MAX_V);
  assign lineValid = syncEdge && inWindow;
  assign lineBad   = (syncEdge && !inWindow) || timeout;

  // Consecutive in-range line counter.
  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst)                runCnt <= '0;
    else if (strobe.runClr) runCnt <= '0;
    else if (strobe.runInc) runCnt <= runCnt + RUN_W'(1);
  end

  assign runLast = (runCnt == RUN_LAST_V);

  // Probation grace timer.
  logic [PROB_W-1:0] probCnt;

  always_ff @(posedge clk) begin
    if (rst)                              probCnt <= '0;
    else if (strobe.probStart)            probCnt <= '0;
    else if (strobe.probRun && !probExpired) probCnt <= probCnt + PROB_W'(1);
  end

  assign probExpired = (probCnt == PROB_LAST_V);

  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    runCnt < RUN_V);

  assert_bad_clears_run_R4: assert property (@(posedge clk) disable iff (rst)
    lineBad |=> (runCnt == '0));

  assert_timer_bounded_R11: assert property (@(posedge clk) disable iff (rst)
    probCnt <= PROB_LAST_V);

  assert_loss_holds_R7: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !lineValid);

endmodule

// File: rtl/syncdet_ctrl.sv
module syncdet_ctrl
  import syncdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lineValid,
  input  logic        lineBad,
  input  logic        runLast,
  input  logic        probExpired,
  output det_strobe_t strobe,
  output logic        syncPresent
);

  det_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_MUTED;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_MUTED: begin
        if (lineBad) begin
          strobe.runClr = 1'b1;
        end else if (lineValid) begin
          if (runLast) begin
            stateNext     = ST_ENABLED;
            strobe.runClr = 1'b1;
          end else begin
            strobe.runInc = 1'b1;
          end
        end
      end
      ST_ENABLED: begin
        if (lineBad) begin
          stateNext        = ST_PROBATION;
          strobe.probStart = 1'b1;
          strobe.runClr    = 1'b1;
        end
      end
      ST_PROBATION: begin
        strobe.probRun = 1'b1;
        if (lineValid && runLast) begin
          stateNext     = ST_ENABLED;
          strobe.runClr = 1'b1;
        end else begin
          if (lineValid) strobe.runInc = 1'b1;
          if (lineBad)   strobe.runClr = 1'b1;
          if (probExpired) begin
            stateNext     = ST_MUTED;
            strobe.runClr = 1'b1;
          end
        end
      end
      default: begin
        stateNext     = ST_MUTED;
        strobe.runClr = 1'b1;
      end
    endcase
  end

  assign syncPresent = (state != ST_MUTED);

  assert_reset_muted_R1: assert property (@(posedge clk)
    rst |=> (state == ST_MUTED));

  assert_unmute_needs_line_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MUTED && !lineValid) |=> (state == ST_MUTED));

  assert_no_direct_mute_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ENABLED) |=> (state != ST_MUTED));

  assert_expiry_mutes_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROBATION && probExpired && !(lineValid && runLast))
      |=> (state == ST_MUTED));

  assert_recovery_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROBATION && lineValid && runLast) |=> (state == ST_ENABLED));

endmodule

// File: rtl/sync_presence_mute.sv
module sync_presence_mute
  import syncdet_pkg::*;
#(
  parameter int MIN_PERIOD  = 6345,
  parameter int MAX_PERIOD  = 10684,
  parameter int PROB_CYCLES = 312500,
  parameter int RUN_LINES   = 8,
  parameter int OUT_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsyncIn,
  input  logic [OUT_W-1:0] rawSync,
  output logic [OUT_W-1:0] gatedSync,
  output logic             syncPresent
);

  det_strobe_t strobe;
  logic lineValid, lineBad, runLast, probExpired;

  syncdet_datapath #(
    .MIN_PERIOD (MIN_PERIOD),
    .MAX_PERIOD (MAX_PERIOD),
    .PROB_CYCLES(PROB_CYCLES),
    .RUN_LINES  (RUN_LINES)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .hsyncIn    (hsyncIn),
    .strobe     (strobe),
    .lineValid  (lineValid),
    .lineBad    (lineBad),
    .runLast    (runLast),
    .probExpired(probExpired)
  );

  syncdet_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .lineValid  (lineValid),
    .lineBad    (lineBad),
    .runLast    (runLast),
    .probExpired(probExpired),
    .strobe     (strobe),
    .syncPresent(syncPresent)
  );

  // Each gated bit passes or is forced high.
  for (genvar b = 0; b < OUT_W; b++) begin : g_gate
    assign gatedSync[b] = rawSync[b] | ~syncPresent;
  end

endmodule

// File: tb/sync_presence_mute_bench.sv
module sync_presence_mute_bench;

  localparam int MINP  = 20;
  localparam int MAXP  = 40;
  localparam int PROB  = 240;
  localparam int RUN   = 8;
  localparam int OUT_W = 3;
  localparam int NSEG  = 14;

  // Table: lines sent, period of each, expected syncPresent afterwards.
  localparam int   SEG_N [NSEG] = '{8, 1, 4, 1, 3, 6, 12, 1, 4, 1, 2, 3, 7, 1};
  localparam int   SEG_P [NSEG] = '{25,25,25,12,25,25,25,60,25,12,25,25,25,25};
  localparam logic SEG_S [NSEG] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 1};
  string segTag [NSEG] = '{"R3", "R3", "R5", "R5", "R6", "R9", "R9",
                           "R7", "R6", "R4", "R11", "R8", "R4", "R3"};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hs  = 1'b0;
  logic [OUT_W-1:0] raw = '0;
  logic [OUT_W-1:0] gatedSync;
  logic             syncPresent;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sync_presence_mute #(
    .MIN_PERIOD (MINP),
    .MAX_PERIOD (MAXP),
    .PROB_CYCLES(PROB),
    .RUN_LINES  (RUN),
    .OUT_W      (OUT_W)
  ) u_sync_presence_mute (
    .clk        (clk),
    .rst        (rst),
    .hsyncIn    (hs),
    .rawSync    (raw),
    .gatedSync  (gatedSync),
    .syncPresent(syncPresent)
  );

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    hs  = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  // One line: rising edge now, next call's edge exactly p cycles later.
  task automatic sendLine(input int p);
    hs = 1'b1;
    repeat (4) @(negedge clk);
    hs = 1'b0;
    repeat (p - 4) @(negedge clk);
  endtask

  task automatic expectState(input string tag, input logic expPresent);
    logic [OUT_W-1:0] expG;
    expG = expPresent ? raw : {OUT_W{1'b1}};
    tests++;
    if (syncPresent !== expPresent) begin
      fails++;
      $display("FAIL %s: syncPresent=%0b expected %0b", tag, syncPresent, expPresent);
    end
    tests++;
    if (gatedSync !== expG) begin
      fails++;
      $display("FAIL %s: gatedSync=%b expected %b", tag, gatedSync, expG);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    doReset();
    raw = 3'b010;
    @(negedge clk);
    expectState("R1", 1'b0);

    // Table walk
    for (int i = 0; i < NSEG; i++) begin
      raw = OUT_W'(i) ^ 3'b101;
      for (int k = 0; k < SEG_N[i]; k++) sendLine(SEG_P[i]);
      expectState(segTag[i], SEG_S[i]);
    end

    // R2: both window limits are in range
    doReset();
    raw = 3'b001;
    begin
      int seqA [9] = '{25, 20, 40, 20, 40, 20, 40, 20, 25};
      for (int k = 0; k < 9; k++) begin
        sendLine(seqA[k]);
        if (k == 7) expectState("R3", 1'b0);
      end
    end
    expectState("R2", 1'b1);

    // R2: one below the lower limit breaks the run; R4 consecutive while muted
    doReset();
    raw = 3'b110;
    for (int k = 0; k < 7; k++) sendLine(25);
    sendLine(19);
    sendLine(25);
    expectState("R2", 1'b0);
    for (int k = 0; k < 7; k++) sendLine(25);
    expectState("R4", 1'b0);
    sendLine(25);
    expectState("R3", 1'b1);

    // R2: one above the upper limit breaks the run
    doReset();
    for (int k = 0; k < 7; k++) sendLine(25);
    sendLine(41);
    sendLine(25);
    expectState("R2", 1'b0);

    // R10: eighth recovery line lands in the expiry cycle
    doReset();
    raw = 3'b011;
    for (int k = 0; k < 9; k++) sendLine(30);
    expectState("R3", 1'b1);
    sendLine(12);
    for (int k = 0; k < 8; k++) sendLine(30);
    expectState("R6", 1'b1);
    sendLine(30);
    expectState("R10", 1'b1);

    // R7 / R8: loss of pulses from enabled
    hs = 1'b0;
    repeat (150) @(negedge clk);
    expectState("R6", 1'b1);
    repeat (150) @(negedge clk);
    expectState("R7", 1'b0);
    raw = 3'b000;
    @(negedge clk);
    expectState("R8", 1'b0);

    finishRun();
  end

endmodule